// File: doc/BRIEF.md
# Shared Address/Data Bus Initiator with Select Timeout

This block is the initiator side of a synchronous parallel bus on which address and data travel over one set of lines. A local client hands it one transaction at a time: a target address, a command code, a direction and a beat count. It then supplies a stream of per-beat byte masks, plus write data for writes. When the bus grant is present the initiator runs one address phase. It waits for a target to claim the cycle with a select signal and then moves data beats. A beat completes only on a clock where both sides are ready. If no target claims the cycle within a fixed window, the initiator abandons the transaction and reports an abort. Either way, a one-clock status pulse marks the end of the transaction.

The 4-bit side field changes meaning between phases. During the address phase it carries the command. During data phases it carries the byte mask of the current beat, and a mask of all zeros (a beat that moves no bytes) is legal. The initiator drops its frame signal while it offers the final beat, so the target knows which beat is last. After every transaction the initiator releases all lines for one turnaround clock.

The client side uses valid/ready streams. The request is taken when `req_valid` and `req_ready` are high on the same edge. Beats are taken when `beat_valid` and `beat_ready` are high together. Once `beat_valid` is raised, the client must hold it, along with its data and mask, until `beat_ready`. Read data comes out through a two-word buffer. `rd_valid` stays high, with `rd_data` unchanged, until the client takes the word with `rd_ready`. When the buffer is full, the initiator withholds its bus ready, and the back-pressure reaches the target as wait states.

Top module: `mbus_initiator`

## Requirements
- R1: While reset is asserted and no request is pending, `bus_req_o`, `frame_o`, `irdy_o`, `ad_oe_o`, `cbe_oe_o`, `done_o` and `rd_valid` are all low.
- R2: `req_ready` is high only when the initiator is idle and `bus_gnt_i` is high. `bus_req_o` is high whenever `req_valid` is high or a transaction is under way, including its turnaround clock. With the grant low, no address phase ever starts.
- R3: The clock after a request is accepted is the address phase, lasting exactly one clock. In it `frame_o`=1, `ad_oe_o`=1, `ad_o`=the request address, `cbe_oe_o`=1, `cbe_o`=the request command and `irdy_o`=0.
- R4: In each data clock `cbe_o` carries the offered beat's mask (bit i enables byte i). `frame_o` is high, except that it is low in any data clock where `irdy_o` is high while the final beat is offered.
- R5: If `devsel_i` is low on every one of the 6 clocks after the address phase, the 7th clock after it is the turnaround clock, with `done_o`=1 and `aborted_o`=1. No beat is consumed.
- R6: A beat completes on exactly the data clocks where `irdy_o`, `trdy_i` and `devsel_i` are all high, and `beat_ready` is high on exactly those clocks. A low `trdy_i` inserts wait states.
- R7: In a data clock `irdy_o` equals `beat_valid` for writes. For reads it equals `beat_valid` while the read buffer holds fewer than 2 unclaimed words. A stalled `irdy_o` keeps the transaction open.
- R8: In data clocks `ad_oe_o` is high for writes and low for reads. For writes, while `irdy_o` is high, `ad_o` equals `beat_data`.
- R9: On each completed read beat, the `ad_i` value is captured. The captured words appear on `rd_data` in beat order, each held with `rd_valid` until taken with `rd_ready`.
- R10: The clock after the final beat or the abort is a turnaround clock. In it `done_o`=1, `aborted_o` shows the outcome, `frame_o`, `irdy_o`, `ad_oe_o` and `cbe_oe_o` are low, and `req_ready` is low. The next clock is idle.
- R11: A transaction with `req_len`=L moves exactly L+1 beats.
- R12: Under a grant that stays high, a new request is accepted in the first idle clock after the turnaround clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this clock |
| req_addr | input | 32 | Target address |
| req_cmd | input | 4 | Command code for the address phase |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 4 | Beat count minus one |
| beat_valid | input | 1 | Beat mask (and write data) offered |
| beat_ready | output | 1 | Beat completed on the bus |
| beat_data | input | 32 | Write data of the offered beat |
| beat_mask | input | 4 | Byte mask of the offered beat |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Read word taken |
| rd_data | output | 32 | Read word |
| done_o | output | 1 | Transaction finished (turnaround clock) |
| aborted_o | output | 1 | With done_o: ended by select timeout |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| frame_o | output | 1 | Transaction frame, low during the last beat |
| ad_o | output | 32 | Shared address/data lines, driven value |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| ad_i | input | 32 | Shared address/data lines, sampled value |
| cbe_o | output | 4 | Command in the address phase, byte mask in data phases |
| cbe_oe_o | output | 1 | Drive enable for cbe_o |
| irdy_o | output | 1 | Initiator ready |
| trdy_i | input | 1 | Target ready |
| devsel_i | input | 1 | Target select |

## Verification
The hardest situations to reach are the edges of the select window: the target answering on the 6th clock after the address phase, and a target that answers one clock too late. The bench sweeps the select delay from 1 to 7 clocks. It crosses this with every beat count up to four, both directions, and three patterns of target wait states, client stalls and read back-pressure. The read back-pressure patterns fill the two-word read buffer mid-burst, so `irdy_o` falls because of the buffer rather than the beat stream.

// File: rtl/mbi_pkg.sv
`timescale 1ns/1ps
package mbi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_TURN = 2'd3
  } mbi_state_e;
endpackage

// File: rtl/mbi_sel_timer.sv
`timescale 1ns/1ps
module mbi_sel_timer #(
  parameter int TMO = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic active_i,
  input  logic devsel_i,
  output logic timeout_o
);
  localparam int CNT_W = $clog2(TMO + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (active_i) begin
      if (devsel_i) begin
        seen_q <= 1'b1;
      end else if (!seen_q && cnt_q != LAST) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign timeout_o = active_i & ~seen_q & ~devsel_i & (cnt_q == LAST);

  AST_SEL_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R5
  AST_SEL_TMO_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !active_i); // R5
endmodule

// File: rtl/mbi_beat_ctr.sv
`timescale 1ns/1ps
module mbi_beat_ctr #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step_i,
  output logic             last_o
);
  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load_i) begin
      rem_q <= len_i;
    end else if (step_i) begin
      rem_q <= rem_q - LEN_W'(1);
    end
  end

  assign last_o = (rem_q == '0);

  AST_BEAT_REM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(rem_q)); // R11
endmodule

// File: rtl/mbi_rd_buf.sv
`timescale 1ns/1ps
module mbi_rd_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  output logic          space_o,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign pop        = rd_valid_o & rd_ready_i;
  assign rd_valid_o = (cnt_q != '0);
  assign space_o    = (cnt_q != CW'(DEPTH));
  assign rd_data_o  = mem_q[rptr_q];

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= step_ptr(wptr_q);
      if (pop)    rptr_q <= step_ptr(rptr_q);
      case ({push_i, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_RDBUF_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> space_o); // R9
  AST_RDBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o))); // R9
endmodule

// File: rtl/mbi_ctrl.sv
`timescale 1ns/1ps
module mbi_ctrl
  import mbi_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  logic [DW-1:0] req_addr_i,
  input  logic [BW-1:0] req_cmd_i,
  input  logic          req_write_i,
  output logic          req_ready_o,
  output logic          accept_o,
  input  logic          beat_valid_i,
  input  logic [DW-1:0] beat_data_i,
  input  logic [BW-1:0] beat_mask_i,
  input  logic          rd_space_i,
  input  logic          last_i,
  input  logic          timeout_i,
  output logic          arm_o,
  output logic          in_data_o,
  output logic          xfer_o,
  output logic          rd_push_o,
  output logic          done_o,
  output logic          aborted_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          frame_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [BW-1:0] cbe_o,
  output logic          cbe_oe_o,
  output logic          irdy_o,
  input  logic          trdy_i,
  input  logic          devsel_i
);
  mbi_state_e    st_q;
  logic [DW-1:0] addr_q;
  logic [BW-1:0] cmd_q;
  logic          wr_q;
  logic          abort_q;

  assign req_ready_o = (st_q == ST_IDLE) & bus_gnt_i;
  assign accept_o    = req_ready_o & req_valid_i;
  assign bus_req_o   = (st_q != ST_IDLE) | req_valid_i;
  assign arm_o       = (st_q == ST_ADDR);
  assign in_data_o   = (st_q == ST_DATA);

  assign irdy_o    = in_data_o & beat_valid_i & (wr_q | rd_space_i);
  assign xfer_o    = irdy_o & trdy_i & devsel_i;
  assign rd_push_o = xfer_o & ~wr_q;
  assign frame_o   = arm_o | (in_data_o & ~(last_i & irdy_o));

  always_comb begin
    ad_o     = '0;
    cbe_o    = '0;
    ad_oe_o  = 1'b0;
    cbe_oe_o = 1'b0;
    if (arm_o) begin
      ad_o     = addr_q;
      cbe_o    = cmd_q;
      ad_oe_o  = 1'b1;
      cbe_oe_o = 1'b1;
    end else if (in_data_o) begin
      cbe_o    = beat_mask_i;
      cbe_oe_o = 1'b1;
      ad_oe_o  = wr_q;
      if (wr_q) ad_o = beat_data_i;
    end
  end

  assign done_o    = (st_q == ST_TURN);
  assign aborted_o = done_o & abort_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      cmd_q   <= '0;
      wr_q    <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept_o) begin
          st_q   <= ST_ADDR;
          addr_q <= req_addr_i;
          cmd_q  <= req_cmd_i;
          wr_q   <= req_write_i;
        end
        ST_ADDR: st_q <= ST_DATA;
        ST_DATA: if (timeout_i || (xfer_o && last_i)) begin
          st_q    <= ST_TURN;
          abort_q <= timeout_i;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_ADDR_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR) |-> $past(bus_gnt_i)); // R2
  AST_FRAME_MARKS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_o && !frame_o) |=> (st_q == ST_TURN)); // R4
  AST_IRDY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy_o && !xfer_o) |=> (irdy_o || st_q == ST_TURN)); // R7
  AST_SINGLE_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TURN) |=> (st_q == ST_IDLE)); // R10
endmodule

// File: rtl/mbus_initiator.sv
`timescale 1ns/1ps
module mbus_initiator #(
  parameter int DW       = 32,
  parameter int LEN_W    = 4,
  parameter int SEL_TMO  = 6,
  parameter int RD_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DW-1:0]     req_addr,
  input  logic [DW/8-1:0]   req_cmd,
  input  logic              req_write,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              beat_valid,
  output logic              beat_ready,
  input  logic [DW-1:0]     beat_data,
  input  logic [DW/8-1:0]   beat_mask,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DW-1:0]     rd_data,
  output logic              done_o,
  output logic              aborted_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              frame_o,
  output logic [DW-1:0]     ad_o,
  output logic              ad_oe_o,
  input  logic [DW-1:0]     ad_i,
  output logic [DW/8-1:0]   cbe_o,
  output logic              cbe_oe_o,
  output logic              irdy_o,
  input  logic              trdy_i,
  input  logic              devsel_i
);
  localparam int BW = DW / 8;

  logic accept, arm, in_data, xfer, rd_push, rd_space, last, timeout;

  mbi_ctrl #(.DW(DW), .BW(BW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_cmd_i(req_cmd),
    .req_write_i(req_write), .req_ready_o(req_ready), .accept_o(accept),
    .beat_valid_i(beat_valid), .beat_data_i(beat_data), .beat_mask_i(beat_mask),
    .rd_space_i(rd_space), .last_i(last), .timeout_i(timeout),
    .arm_o(arm), .in_data_o(in_data), .xfer_o(xfer), .rd_push_o(rd_push),
    .done_o(done_o), .aborted_o(aborted_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
    .frame_o(frame_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .cbe_o(cbe_o), .cbe_oe_o(cbe_oe_o), .irdy_o(irdy_o),
    .trdy_i(trdy_i), .devsel_i(devsel_i)
  );

  mbi_sel_timer #(.TMO(SEL_TMO)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .active_i(in_data),
    .devsel_i(devsel_i), .timeout_o(timeout)
  );

  mbi_beat_ctr #(.LEN_W(LEN_W)) u_beats (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .len_i(req_len),
    .step_i(xfer), .last_o(last)
  );

  mbi_rd_buf #(.DW(DW), .DEPTH(RD_DEPTH)) u_rdbuf (
    .clk(clk), .rst_n(rst_n), .push_i(rd_push), .push_data_i(ad_i),
    .space_o(rd_space), .rd_valid_o(rd_valid), .rd_ready_i(rd_ready),
    .rd_data_o(rd_data)
  );

  assign beat_ready = xfer;
endmodule

// File: tb/mbus_initiator_tb.sv
`timescale 1ns/1ps
module mbus_initiator_tb;
  localparam int TMO = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_cmd = '0, req_len = '0;
  logic        beat_valid = 1'b0, rd_ready = 1'b0;
  logic [31:0] beat_data = '0, ad_i = '0;
  logic [3:0]  beat_mask = '0;
  logic        bus_gnt_i = 1'b0, trdy_i = 1'b0, devsel_i = 1'b0;
  logic        req_ready, beat_ready, rd_valid, done_o, aborted_o, bus_req_o;
  logic        frame_o, ad_oe_o, cbe_oe_o, irdy_o;
  logic [31:0] rd_data, ad_o;
  logic [3:0]  cbe_o;

  int n_cmp = 0, n_bad = 0, txn_id = 0;

  always #4 clk = ~clk;

  mbus_initiator u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_write(req_write), .req_len(req_len),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_data(beat_data),
    .beat_mask(beat_mask), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .done_o(done_o), .aborted_o(aborted_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .frame_o(frame_o),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i), .cbe_o(cbe_o),
    .cbe_oe_o(cbe_oe_o), .irdy_o(irdy_o), .trdy_i(trdy_i), .devsel_i(devsel_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (txn %0d, t=%0t)", tag, act, exp, txn_id, $time);
    end
  endtask

  function automatic logic [31:0] wdat(input int b, input logic [3:0] s);
    return 32'hC0DE_0000 ^ {s, 28'h0} ^ (32'(b) * 32'h0101_0001);
  endfunction
  function automatic logic [3:0] wmsk(input int b, input logic [3:0] s);
    return 4'(b * 3) + s;
  endfunction
  function automatic logic [31:0] rdat(input int b, input logic [3:0] s);
    return 32'h5A00_0000 + (32'(b) << 8) + 32'(s);
  endfunction

  logic [7:0] tr_pat [3] = '{8'hFF, 8'b1011_0101, 8'b0110_0011};
  logic [7:0] st_pat [3] = '{8'h00, 8'b0001_0010, 8'b1000_1100};
  logic [7:0] rr_pat [3] = '{8'hFF, 8'b1101_1001, 8'b0011_0110};

  task automatic run_txn(input bit wr, input int len, input int dly, input int pat);
    int ph, nb, rgot, rd_exp;
    bit fin, ab_exp, bvh, xe, ei;
    logic [3:0] seed;
    logic [31:0] a;
    seed = 4'(txn_id * 7);
    ab_exp = (dly > TMO);
    a = 32'h4000_0000 + 32'(txn_id) * 32'd16;
    req_valid = 1'b1; req_addr = a; req_cmd = 4'(txn_id * 5);
    req_write = wr; req_len = 4'(len);
    #1;
    chk(req_ready === 1'b1, "R12 accept in first idle clock", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    ph = 0; nb = 0; rgot = 0; fin = 0; bvh = 0;
    forever begin
      rd_exp = wr ? 0 : nb;
      if (fin && rgot == rd_exp) break;
      if (!fin) begin
        devsel_i   = (ph >= 1) && (ph >= dly);
        trdy_i     = devsel_i && tr_pat[pat][ph % 8];
        beat_valid = (ph >= 1) && (bvh || !st_pat[pat][ph % 8]);
      end else begin
        devsel_i = 1'b0; trdy_i = 1'b0; beat_valid = 1'b0;
      end
      beat_data = wdat(nb, seed); beat_mask = wmsk(nb, seed); ad_i = rdat(nb, seed);
      rd_ready = rr_pat[pat][ph % 8];
      xe = 1'b0;
      #1;
      if (!fin) begin
        if (ph == 0) begin
          chk(frame_o === 1'b1 && irdy_o === 1'b0, "R3 frame/irdy in address phase", {frame_o, irdy_o}, 32'b10);
          chk(ad_oe_o === 1'b1 && ad_o === a, "R3 address on lines", ad_o, a);
          chk(cbe_oe_o === 1'b1 && cbe_o === req_cmd, "R3 command field", 32'(cbe_o), 32'(req_cmd));
        end else if (!done_o) begin
          chk(!(ab_exp && ph > TMO), "R5 abort not yet reported", 32'(ph), 32'(TMO + 1));
          ei = beat_valid && (wr || (nb - rgot) < 2);
          chk(irdy_o === ei, "R7 initiator ready", 32'(irdy_o), 32'(ei));
          xe = ei && trdy_i && devsel_i;
          chk(beat_ready === xe, "R6 beat completion", 32'(beat_ready), 32'(xe));
          chk(frame_o === !(ei && nb == len), "R4 frame marks last beat", 32'(frame_o), 32'(!(ei && nb == len)));
          if (ei) chk(cbe_o === wmsk(nb, seed), "R4 byte mask", 32'(cbe_o), 32'(wmsk(nb, seed)));
          chk(ad_oe_o === wr, "R8 data drive enable", 32'(ad_oe_o), 32'(wr));
          if (wr && ei) chk(ad_o === wdat(nb, seed), "R8 write data", ad_o, wdat(nb, seed));
        end else begin
          fin = 1'b1;
          chk(aborted_o === ab_exp, "R10 outcome flag", 32'(aborted_o), 32'(ab_exp));
          if (ab_exp) begin
            chk(ph == TMO + 1, "R5 abort clock", 32'(ph), 32'(TMO + 1));
            chk(nb == 0, "R5 no beat on abort", 32'(nb), 32'd0);
          end else begin
            chk(nb == len + 1, "R11 beat count", 32'(nb), 32'(len + 1));
          end
          chk(!frame_o && !irdy_o && !ad_oe_o && !cbe_oe_o && !req_ready,
              "R10 lines released", {frame_o, irdy_o, ad_oe_o, cbe_oe_o, req_ready}, 32'd0);
        end
      end
      if (rd_valid && rd_ready) begin
        chk(!wr && rd_data === rdat(rgot, seed), "R9 read word", rd_data, rdat(rgot, seed));
        rgot++;
      end
      if (xe) nb++;
      bvh = beat_valid && !xe;
      ph++;
      if (ph > 400) begin
        chk(1'b0, "R10 transaction never ended", 32'(ph), 32'd0);
        break;
      end
      @(negedge clk);
    end
    devsel_i = 1'b0; trdy_i = 1'b0; beat_valid = 1'b0; rd_ready = 1'b0;
    txn_id++;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(!bus_req_o && !frame_o && !irdy_o && !ad_oe_o && !cbe_oe_o && !done_o && !rd_valid,
        "R1 reset outputs", {bus_req_o, frame_o, irdy_o, ad_oe_o, cbe_oe_o, done_o, rd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: request without grant
    req_valid = 1'b1; req_write = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk(req_ready === 1'b0 && bus_req_o === 1'b1 && frame_o === 1'b0,
          "R2 no start without grant", {req_ready, bus_req_o, frame_o}, 32'b010);
      @(negedge clk);
    end
    req_valid = 1'b0;
    #1;
    chk(bus_req_o === 1'b0, "R2 request dropped", 32'(bus_req_o), 32'd0);
    @(negedge clk);
    bus_gnt_i = 1'b1;
    for (int p = 0; p < 3; p++)
      for (int w = 0; w < 2; w++)
        for (int l = 0; l < 4; l++)
          for (int d = 1; d <= TMO + 1; d++)
            run_txn(w[0], l, d, p);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule